// File: doc/BRIEF.md
# Balancing Supervisor with Watchdog

This block decides whether a stored six-channel balance command is actually allowed to drive the balancer outputs. Upstream logic decodes the serial port and presents one event per valid command byte, with its operation type and, for writes, a 12-bit payload. A write fills a pending command register. An execute copies the pending register into the active register and starts balancing.

While balancing, a watchdog counts clock cycles between valid command bytes. Any valid byte restarts the count. If the count runs out, all outputs are forced off. They come back only after a fresh execute, although later bytes of any other type still clear the count. An external pause input and a thermal-fault flag also force the outputs off. Both resume the same stored command automatically once they clear.

A power-on/undervoltage flag returns everything to its default state. A defeat strap disables the watchdog. A single-transformer strap makes the block reject any execute that would enable more than one channel at once.

Top module: `bal_supervisor`

## Requirements
- R1: After `rst_n` low or `por_flag` high at a clock edge, `bal_en` is 0, `wd_timeout` is 0, and both command registers are cleared, so a following execute drives all zeros. While `por_flag` is high, `bal_en` is 0 in the same cycle.
- R2: A write (`byte_op`=01) loads `byte_data` into the pending register and leaves `bal_en` unchanged. An execute (`byte_op`=00) copies the pending register to the active register, which appears on `bal_en` at the next edge. Channel i occupies bits [2i+1:2i], and code 00 means idle.
- R3: With no gating condition, `bal_en` equals the active register. `bal_active` is high exactly when `bal_en` is non-zero.
- R4: After an accepted execute sampled at edge E, with no further valid byte, `wd_timeout` rises at edge E+WD_CYCLES and not earlier. While it is high, `bal_en` is 0.
- R5: Any valid byte clears the watchdog count: execute, write, command read (10) or status read (11). Bytes spaced WD_CYCLES-1 edges apart keep balancing running indefinitely.
- R6: Once timed out, writes and reads leave `wd_timeout` high and `bal_en` 0. An accepted execute clears the timeout and drives the stored active command again.
- R7: While `pause_req` is high, `bal_en` is 0 in the same cycle. Releasing it restores the stored command without a new execute.
- R8: While `thermal_fault` is high, `bal_en` is 0 in the same cycle. When it clears, the stored command returns without a new execute.
- R9: While `wd_defeat` is high, `wd_timeout` never rises and the count is held at zero.
- R10: With `single_xfmr` high, an execute whose pending command has more than one non-zero channel code is ignored, and `bal_en` keeps its previous value. Commands with at most one active channel are accepted. With `single_xfmr` low, every execute is accepted.
- R11: Before the first accepted execute, the watchdog does not run, so `wd_timeout` stays 0 however long the bus is idle.
- R12: Command reads (10) and status reads (11) change neither the pending nor the active register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_flag | input | 1 | Power-on/undervoltage clear, active high |
| byte_valid | input | 1 | One-cycle strobe: a valid command byte was decoded |
| byte_op | input | 2 | Byte type: 00 execute, 01 write, 10 read command, 11 read status |
| byte_data | input | 12 | Write payload, six 2-bit channel codes |
| pause_req | input | 1 | External pause, active high |
| thermal_fault | input | 1 | Overtemperature flag (hysteresis applied upstream) |
| wd_defeat | input | 1 | Strap: disable the watchdog |
| single_xfmr | input | 1 | Strap: shared-transformer mode, at most one channel |
| bal_en | output | 12 | Gated per-channel balancer codes |
| wd_timeout | output | 1 | Watchdog has expired |
| bal_active | output | 1 | At least one channel is being driven |

## Verification
The hardest state to reach is the exact expiry edge of the watchdog. The bench reaches it by sending a byte, then counting falling edges precisely. It checks that the timeout is still low one cycle before WD_CYCLES and high on that cycle. It then confirms that reads and writes issued in the timed-out state do not revive the outputs.

Single-transformer rejection is swept over all 64 channel-occupancy patterns. Before each pattern, the bench re-establishes a known single-channel prior command, so that an ignored execute can be seen as the prior value persisting on `bal_en`.

// File: rtl/bal_sup_pkg.sv
// Shared definitions for the balancing supervisor.
// Assumes the serial decoder presents the byte type on two bits.
package bal_sup_pkg;

    typedef enum logic [1:0] {
        OP_EXEC   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_RDCMD  = 2'b10,
        OP_RDSTAT = 2'b11
    } bal_op_e;

endpackage

// File: rtl/bal_cmd_store.sv
// Pending and active command registers.
// A write loads the pending register. An execute copies it to the active register
// unless single-transformer mode forbids more than one busy channel.
// Assumes byte_valid is a one-cycle strobe per decoded byte.
module bal_cmd_store #(
    parameter int NCH    = 6,
    parameter int CODE_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  byte_valid,
    input  logic [1:0]            byte_op,
    input  logic [NCH*CODE_W-1:0] byte_data,
    input  logic                  single_xfmr,
    output logic [NCH*CODE_W-1:0] active_cmd,
    output logic                  executing,
    output logic                  exec_accept
);
    import bal_sup_pkg::*;

    localparam int W = NCH * CODE_W;

    logic [W-1:0]   pend_q;
    logic [W-1:0]   act_q;
    logic           exe_q;
    logic [NCH-1:0] busy;
    logic           too_many;

    // Flag each pending channel whose code is not idle.
    for (genvar i = 0; i < NCH; i++) begin : g_busy
        assign busy[i] = |pend_q[i*CODE_W +: CODE_W];
    end

    // Decide whether a shared-transformer rule rejects the pending command.
    always_comb begin
        too_many = single_xfmr && ($countones(busy) > 1);
    end

    // Qualify an execute byte into an accepted copy.
    always_comb begin
        exec_accept = byte_valid && (bal_op_e'(byte_op) == OP_EXEC) && !too_many && !clear;
    end

    // Hold pending, active and executing state.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pend_q <= '0;
            act_q  <= '0;
            exe_q  <= 1'b0;
        end else begin
            if (byte_valid && (bal_op_e'(byte_op) == OP_WRITE)) begin
                pend_q <= byte_data;
            end
            if (exec_accept) begin
                act_q <= pend_q;
                exe_q <= 1'b1;
            end
        end
    end

    assign active_cmd = act_q;
    assign executing  = exe_q;

endmodule

// File: rtl/bal_wd_timer.sv
// Communication watchdog.
// Counts cycles while a command is executing and clears on every valid byte.
// Flags a timeout after WD_CYCLES quiet cycles.
// The flag clears only on an accepted execute.
// Assumes WD_CYCLES >= 2.
module bal_wd_timer #(
    parameter int WD_CYCLES = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic kick,
    input  logic exec_accept,
    input  logic defeat,
    output logic timeout
);
    localparam int              CNT_W = $clog2(WD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(WD_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             to_q;

    // Advance, clear or expire the watchdog count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
            to_q  <= 1'b0;
        end else if (exec_accept) begin
            cnt_q <= '0;
            to_q  <= 1'b0;
        end else if (kick || to_q || !run || defeat) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            to_q  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign timeout = to_q;

endmodule

// File: rtl/bal_out_gate.sv
// Output gating: each active channel code reaches the pins only while
// executing and free of timeout, pause, thermal fault and reset.
// Pause, thermal and reset act in the same cycle (combinational path).
module bal_out_gate #(
    parameter int NCH    = 6,
    parameter int CODE_W = 2
) (
    input  logic [NCH*CODE_W-1:0] active_cmd,
    input  logic                  executing,
    input  logic                  timeout,
    input  logic                  pause_req,
    input  logic                  thermal_fault,
    input  logic                  por_flag,
    output logic [NCH*CODE_W-1:0] bal_en,
    output logic                  bal_active
);
    logic           allow;
    logic [NCH-1:0] drv;

    // Combine every inhibit into one permission bit.
    always_comb begin
        allow = executing && !timeout && !pause_req && !thermal_fault && !por_flag;
    end

    // Gate each channel code and note whether it drives.
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign bal_en[i*CODE_W +: CODE_W] = allow ? active_cmd[i*CODE_W +: CODE_W] : '0;
        assign drv[i] = allow && (|active_cmd[i*CODE_W +: CODE_W]);
    end

    assign bal_active = |drv;

endmodule

// File: rtl/bal_supervisor.sv
// Balancing supervisor top.
// Ties the command store, the watchdog and the output gate together.
// Assumes byte events are already decoded, synchronised and address-checked.
module bal_supervisor #(
    parameter int NCH       = 6,
    parameter int CODE_W    = 2,
    parameter int WD_CYCLES = 30_000_000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  por_flag,
    input  logic                  byte_valid,
    input  logic [1:0]            byte_op,
    input  logic [NCH*CODE_W-1:0] byte_data,
    input  logic                  pause_req,
    input  logic                  thermal_fault,
    input  logic                  wd_defeat,
    input  logic                  single_xfmr,
    output logic [NCH*CODE_W-1:0] bal_en,
    output logic                  wd_timeout,
    output logic                  bal_active
);
    logic [NCH*CODE_W-1:0] active_cmd;
    logic                  executing;
    logic                  exec_accept;

    bal_cmd_store #(.NCH(NCH), .CODE_W(CODE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(por_flag),
        .byte_valid(byte_valid), .byte_op(byte_op), .byte_data(byte_data),
        .single_xfmr(single_xfmr),
        .active_cmd(active_cmd), .executing(executing), .exec_accept(exec_accept)
    );

    bal_wd_timer #(.WD_CYCLES(WD_CYCLES)) u_wd (
        .clk(clk), .rst_n(rst_n), .clear(por_flag),
        .run(executing), .kick(byte_valid), .exec_accept(exec_accept),
        .defeat(wd_defeat), .timeout(wd_timeout)
    );

    bal_out_gate #(.NCH(NCH), .CODE_W(CODE_W)) u_gate (
        .active_cmd(active_cmd), .executing(executing), .timeout(wd_timeout),
        .pause_req(pause_req), .thermal_fault(thermal_fault), .por_flag(por_flag),
        .bal_en(bal_en), .bal_active(bal_active)
    );

endmodule

// File: rtl/bal_supervisor_chk.sv
// Property checker for the balancing supervisor, bound to the top module.
module bal_supervisor_chk #(
    parameter int NCH    = 6,
    parameter int CODE_W = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  por_flag,
    input logic                  byte_valid,
    input logic [1:0]            byte_op,
    input logic                  pause_req,
    input logic                  thermal_fault,
    input logic                  wd_defeat,
    input logic [NCH*CODE_W-1:0] bal_en,
    input logic                  wd_timeout,
    input logic                  bal_active
);
    // R4
    timeout_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_timeout |-> (bal_en == '0));

    // R7
    pause_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |-> (bal_en == '0));

    // R8
    thermal_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thermal_fault |-> (bal_en == '0));

    // R9
    defeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_defeat && !wd_timeout) |=> !wd_timeout);

    // R6
    resume_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_timeout && !por_flag && !(byte_valid && byte_op == 2'b00)) |=> wd_timeout);

    // R1
    por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_flag |=> (!wd_timeout && bal_en == '0));

    // R3
    active_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bal_active == (bal_en != '0));

endmodule

bind bal_supervisor bal_supervisor_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .por_flag(por_flag),
    .byte_valid(byte_valid), .byte_op(byte_op),
    .pause_req(pause_req), .thermal_fault(thermal_fault), .wd_defeat(wd_defeat),
    .bal_en(bal_en), .wd_timeout(wd_timeout), .bal_active(bal_active)
);

// File: tb/sim_bal_supervisor.sv
module sim_bal_supervisor;
    localparam int NCH = 6;
    localparam int CW  = 2;
    localparam int W   = NCH * CW;
    localparam int WD  = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         por_flag = 1'b0;
    logic         byte_valid = 1'b0;
    logic [1:0]   byte_op = 2'b00;
    logic [W-1:0] byte_data = '0;
    logic         pause_req = 1'b0;
    logic         thermal_fault = 1'b0;
    logic         wd_defeat = 1'b0;
    logic         single_xfmr = 1'b0;
    logic [W-1:0] bal_en;
    logic         wd_timeout;
    logic         bal_active;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    bal_supervisor #(.NCH(NCH), .CODE_W(CW), .WD_CYCLES(WD)) u0 (
        .clk(clk), .rst_n(rst_n), .por_flag(por_flag),
        .byte_valid(byte_valid), .byte_op(byte_op), .byte_data(byte_data),
        .pause_req(pause_req), .thermal_fault(thermal_fault),
        .wd_defeat(wd_defeat), .single_xfmr(single_xfmr),
        .bal_en(bal_en), .wd_timeout(wd_timeout), .bal_active(bal_active)
    );

    // Watchdog on the bench itself
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic send(input logic [1:0] op, input logic [W-1:0] d);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_op    = op;
        byte_data  = d;
        @(negedge clk);
        byte_valid = 1'b0;
        #1;
    endtask

    function automatic logic [W-1:0] mask_cmd(input int m);
        logic [W-1:0] r = '0;
        for (int i = 0; i < NCH; i++)
            if (m[i]) r[i*CW +: CW] = CW'((i % 3) + 1);
        return r;
    endfunction

    initial begin
        logic [W-1:0] cmd_a;
        logic [W-1:0] cmd_b;
        cmd_a = 12'b01_00_10_00_11_01;
        cmd_b = 12'b00_11_00_00_00_00;

        // R1: reset state
        tick(3);
        chk("R1 reset bal_en", bal_en, '0);
        chk("R1 reset timeout", W'(wd_timeout), '0);
        rst_n = 1'b1;
        tick(1);

        // R11: idle bus never times out before the first execute
        tick(3 * WD);
        chk("R11 idle no timeout", W'(wd_timeout), '0);

        // R2 / R12: write then reads leave outputs alone
        send(2'b01, cmd_a);
        chk("R2 write no output change", bal_en, '0);
        send(2'b10, '1);
        send(2'b11, '1);
        chk("R12 reads no output change", bal_en, '0);
        send(2'b00, '0);
        chk("R2 execute drives command", bal_en, cmd_a);
        chk("R3 active flag", W'(bal_active), W'(1));
        chk("R12 reads did not alter pending", bal_en, cmd_a);

        // R5: each byte type keeps the watchdog alive
        for (int k = 0; k < 8; k++) begin
            tick(WD - 3);
            send(2'(k % 4 == 0 ? 1 : (k % 4)), cmd_a);
            if (k % 4 == 0) send(2'b00, '0);
        end
        chk("R5 keepalive no timeout", W'(wd_timeout), '0);
        chk("R5 keepalive outputs", bal_en, cmd_a);

        // R4: exact expiry edge
        tick(WD - 1);
        chk("R4 one cycle before expiry", W'(wd_timeout), '0);
        chk("R4 outputs still on", bal_en, cmd_a);
        tick(1);
        chk("R4 expired", W'(wd_timeout), W'(1));
        chk("R4 outputs forced off", bal_en, '0);
        chk("R3 inactive when forced off", W'(bal_active), '0);

        // R6: non-execute bytes do not resume
        send(2'b10, '0);
        send(2'b11, '0);
        chk("R6 reads keep timeout", W'(wd_timeout), W'(1));
        chk("R6 reads keep outputs off", bal_en, '0);
        send(2'b00, '0);
        chk("R6 execute resumes stored command", bal_en, cmd_a);
        chk("R6 execute clears timeout", W'(wd_timeout), '0);

        // R7 / R8: pause and thermal sweep
        for (int g = 1; g < 4; g++) begin
            @(negedge clk);
            pause_req     = g[0];
            thermal_fault = g[1];
            #1;
            chk(g[0] ? "R7 pause same cycle" : "R8 thermal same cycle", bal_en, '0);
            tick(3);
            chk(g[0] ? "R7 pause held" : "R8 thermal held", bal_en, '0);
            @(negedge clk);
            pause_req     = 1'b0;
            thermal_fault = 1'b0;
            #1;
            chk(g[0] ? "R7 resume after pause" : "R8 resume after thermal", bal_en, cmd_a);
            send(2'b11, '0);
        end

        // R9: defeat strap
        wd_defeat = 1'b1;
        tick(3 * WD);
        chk("R9 defeat no timeout", W'(wd_timeout), '0);
        chk("R9 defeat outputs on", bal_en, cmd_a);
        @(negedge clk);
        wd_defeat = 1'b0;
        tick(WD + 1);
        chk("R9 timeout after defeat removed", W'(wd_timeout), W'(1));
        send(2'b00, '0);

        // R10: single-transformer sweep over all occupancy masks
        single_xfmr = 1'b1;
        for (int m = 0; m < 64; m++) begin
            logic [W-1:0] prior;
            logic [W-1:0] cand;
            logic [W-1:0] exp;
            prior = W'(2) << (2 * (m % NCH));
            cand  = mask_cmd(m);
            send(2'b01, prior);
            send(2'b00, '0);
            send(2'b01, cand);
            send(2'b00, '0);
            exp = ($countones(m[5:0]) <= 1) ? cand : prior;
            chk("R10 single mode execute", bal_en, exp);
        end
        single_xfmr = 1'b0;
        send(2'b01, mask_cmd(63));
        send(2'b00, '0);
        chk("R10 normal mode multi accepted", bal_en, mask_cmd(63));

        // R1: power-on clear
        send(2'b01, cmd_b);
        @(negedge clk);
        por_flag = 1'b1;
        #1;
        chk("R1 por same cycle", bal_en, '0);
        @(negedge clk);
        por_flag = 1'b0;
        #1;
        chk("R1 por outputs off", bal_en, '0);
        chk("R1 por timeout low", W'(wd_timeout), '0);
        send(2'b00, '0);
        chk("R1 por cleared pending", bal_en, '0);

        // R1: rst_n mid-run
        send(2'b01, cmd_b);
        send(2'b00, '0);
        chk("R2 second command", bal_en, cmd_b);
        @(negedge clk);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        chk("R1 rst clears active", bal_en, '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule